// File: doc/BRIEF.md
# Three-wire synchronous serial shift unit

This block is a small serial engine for full-duplex byte exchange over a data-out line, a data-in line and a serial clock, in clock-idle-low SPI modes 0 and 1. One shift register holds the byte being sent and, bit by bit, the byte being received. A bit counter advances in lockstep with it, so that a completed byte shows up as a counter wrap. That wrap raises a done flag and can raise an interrupt.

The bit clock has three possible sources: an external serial clock pin, seen through a synchronizer; a pulse from a timer compare match; or a strobe bit written by software. With either of the last two sources the unit drives its own serial clock output by toggling it, which makes it a master. With the pin as source it is a slave.

There is no select line and no receive buffer. Software reads the received byte before it starts the next exchange, and handles any device selection outside the block. Registers are reached through a simple select, write-strobe and read-data port.

Top module: `tws_unit`

## Requirements
- R1: After reset the data, status and control registers read 0, and `sdo`, `sclk_out` and `irq` are 0.
- R2: Register select 0 is the data register, 1 is status and 2 is control; select 3 reads 0. Control bit 0 picks the mode, bits 2:1 the clock source and bit 3 the interrupt enable, and these fields read back as written. A data write loads the shift register and sets `sdo` to the written bit 7.
- R3: The clock source field decodes as 0 = none, 1 = external pin, 2 = timer pulse, 3 = software strobe. A source that is not selected changes neither the counter, nor the data register, nor `sclk_out`.
- R4: With software source selected, a control write with bit 4 set toggles `sclk_out` and makes one clock edge. Bit 4 always reads 0.
- R5: With timer source selected, each cycle with `tmr_match` high toggles `sclk_out` and makes one clock edge.
- R6: The counter in status bits 3:0 goes up by one on every clock edge, rising or falling.
- R7: The counter wraps from 15 to 0 after 16 edges (8 clock periods), and the wrap sets the done flag in status bit 7. At that point the data register holds the 8 bits sampled from `sdi`, first sample in bit 7. The previous contents are overwritten.
- R8: Mode 0 (control bit 0 = 0) samples `sdi` on rising edges and updates `sdo` on falling edges. Mode 1 updates `sdo` on rising edges and samples on falling edges. `sdo` shows the shift register MSB as latched at the last update edge or data write.
- R9: A status write sets the counter to write bits 3:0. It clears the done flag when write bit 7 is 1, and leaves the flag as it was when write bit 7 is 0.
- R10: `irq` is high exactly when the done flag is set and the interrupt enable (control bit 3) is 1.
- R11: In a cycle where several things happen at once, a wrap sets the flag even if a clearing status write arrives in the same cycle, a data write wins over a shift, and a counter preset wins over an increment.
- R12: An `sclk_pin` level change first sampled at clock edge k affects the counter and data register at clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select (0 data, 1 status, 2 control) |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| sclk_pin | input | 1 | External serial clock (asynchronous) |
| tmr_match | input | 1 | Timer compare-match pulse |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sclk_out | output | 1 | Serial clock driven when the unit is master |
| irq | output | 1 | Byte-done interrupt request |

## Verification
Two functions can land in the same cycle: a clock edge coming from the timer pulse, and a register write from the bus. The bench drives `tmr_match` in the very cycle of a status write that clears the flag and presets the counter. It does this just as the counter sits at 15, and it also drives the pulse in the cycle of a data write. It then checks that the flag is still set, that the counter holds the preset value, and that the data register holds the written byte and not a shifted one. A cycle-by-cycle reference model, built from the stated priorities, is compared with every output on every clock through these collisions.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_PIN = 2'd1,
        SRC_TMR = 2'd2,
        SRC_SW  = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTL_MODE_BIT  = 0;
    localparam int CTL_SRC_LSB   = 1;
    localparam int CTL_IRQEN_BIT = 3;
    localparam int CTL_STRB_BIT  = 4;

    typedef struct packed {
        logic     irq_en;
        clk_src_e src;
        logic     cpha;
    } ctrl_t;

endpackage

// File: rtl/tws_clkgen.sv
`timescale 1ns/1ps
module tws_clkgen
    import tws_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src,
    input  logic     tmr_match,
    input  logic     sw_strobe,
    input  logic     sclk_pin,
    output logic     edge_o,
    output logic     rise_o,
    output logic     sclk_o
);
    localparam int CHAIN = SYNC_DEPTH + 1;

    typedef struct packed {
        logic [CHAIN-1:0] chain;
        logic             sclk;
    } clk_st_t;

    clk_st_t st_q, st_d;
    logic    ext_edge, ext_rise, int_tick;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN-2:0], sclk_pin};
        ext_edge   = st_q.chain[CHAIN-1] ^ st_q.chain[CHAIN-2];
        ext_rise   = st_q.chain[CHAIN-2];
        int_tick   = ((src == SRC_TMR) && tmr_match) || ((src == SRC_SW) && sw_strobe);
        if (int_tick) begin
            st_d.sclk = ~st_q.sclk;
        end
        if (src == SRC_PIN) begin
            edge_o = ext_edge;
            rise_o = ext_rise;
        end else begin
            edge_o = int_tick;
            rise_o = ~st_q.sclk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o = st_q.sclk;

    AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_TMR && src != SRC_SW) |=> $stable(sclk_o)); // R3
    AST_SW_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_SW && sw_strobe) |=> (sclk_o != $past(sclk_o))); // R4
    AST_TMR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_TMR && tmr_match) |=> (sclk_o != $past(sclk_o))); // R5

endmodule

// File: rtl/tws_shifter.sv
`timescale 1ns/1ps
module tws_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic              rise_i,
    input  logic              cpha,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              sdi,
    output logic [DATA_W-1:0] sr_o,
    output logic              sdo
);
    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic              obit;
    } sh_st_t;

    sh_st_t sh_q, sh_d;
    logic   sample;

    always_comb begin
        sh_d   = sh_q;
        sample = rise_i ^ cpha;
        if (load) begin
            sh_d.sr   = load_val;
            sh_d.obit = load_val[DATA_W-1];
        end else if (edge_i) begin
            if (sample) begin
                sh_d.sr = {sh_q.sr[DATA_W-2:0], sdi};
            end else begin
                sh_d.obit = sh_q.sr[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sr_o = sh_q.sr;
    assign sdo  = sh_q.obit;

    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sr_o == $past(load_val)) && (sdo == $past(load_val[DATA_W-1]))); // R2
    AST_SAMPLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && (rise_i ^ cpha) && !load) |=> (sr_o == {$past(sr_o[DATA_W-2:0]), $past(sdi)})); // R8
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(edge_i && !(rise_i ^ cpha))) |=> $stable(sdo)); // R8
    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !edge_i) |=> $stable(sr_o)); // R3

endmodule

// File: rtl/tws_counter.sv
`timescale 1ns/1ps
module tws_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             preset,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             clr_req,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } cn_st_t;

    cn_st_t cn_q, cn_d;
    logic   wrap;

    always_comb begin
        cn_d = cn_q;
        wrap = edge_i && (cn_q.cnt == CNT_TOP);
        if (preset) begin
            cn_d.cnt = preset_val;
        end else if (edge_i) begin
            cn_d.cnt = cn_q.cnt + 1'b1;
        end
        cn_d.flag = wrap || (cn_q.flag && !clr_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cn_q <= '0;
        end else begin
            cn_q <= cn_d;
        end
    end

    assign cnt_o  = cn_q.cnt;
    assign flag_o = cn_q.flag;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !preset) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R6
    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && cnt_o == CNT_TOP) |=> flag_o); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && cnt_o == CNT_TOP && clr_req) |=> flag_o); // R11
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(edge_i && cnt_o == CNT_TOP)) |=> !flag_o); // R9
    AST_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (cnt_o == $past(preset_val))); // R9

endmodule

// File: rtl/tws_unit.sv
`timescale 1ns/1ps
module tws_unit
    import tws_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk_pin,
    input  logic              tmr_match,
    input  logic              sdi,
    output logic              sdo,
    output logic              sclk_out,
    output logic              irq
);
    localparam int CNT_W    = $clog2(2 * DATA_W);
    localparam int FLAG_BIT = DATA_W - 1;

    typedef struct packed {
        ctrl_t ctrl;
    } top_st_t;

    top_st_t top_q, top_d;

    logic              wr_data, wr_stat, wr_ctrl, sw_strobe;
    logic              clk_edge, clk_rise;
    logic [DATA_W-1:0] sr_val;
    logic [CNT_W-1:0]  cnt_val;
    logic              done_flag;

    always_comb begin
        top_d     = top_q;
        wr_data   = bus_wr && (reg_sel_e'(bus_sel) == SEL_DATA);
        wr_stat   = bus_wr && (reg_sel_e'(bus_sel) == SEL_STAT);
        wr_ctrl   = bus_wr && (reg_sel_e'(bus_sel) == SEL_CTRL);
        sw_strobe = wr_ctrl && bus_wdata[CTL_STRB_BIT];
        if (wr_ctrl) begin
            top_d.ctrl.cpha   = bus_wdata[CTL_MODE_BIT];
            top_d.ctrl.src    = clk_src_e'(bus_wdata[CTL_SRC_LSB+1:CTL_SRC_LSB]);
            top_d.ctrl.irq_en = bus_wdata[CTL_IRQEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    tws_clkgen #(.SYNC_DEPTH(SYNC_DEPTH)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (top_q.ctrl.src),
        .tmr_match (tmr_match),
        .sw_strobe (sw_strobe),
        .sclk_pin  (sclk_pin),
        .edge_o    (clk_edge),
        .rise_o    (clk_rise),
        .sclk_o    (sclk_out)
    );

    tws_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (clk_edge),
        .rise_i   (clk_rise),
        .cpha     (top_q.ctrl.cpha),
        .load     (wr_data),
        .load_val (bus_wdata),
        .sdi      (sdi),
        .sr_o     (sr_val),
        .sdo      (sdo)
    );

    tws_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (clk_edge),
        .preset     (wr_stat),
        .preset_val (bus_wdata[CNT_W-1:0]),
        .clr_req    (wr_stat && bus_wdata[FLAG_BIT]),
        .cnt_o      (cnt_val),
        .flag_o     (done_flag)
    );

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_sel))
            SEL_DATA: bus_rdata = sr_val;
            SEL_STAT: begin
                bus_rdata[CNT_W-1:0] = cnt_val;
                bus_rdata[FLAG_BIT]  = done_flag;
            end
            SEL_CTRL: begin
                bus_rdata[CTL_MODE_BIT]                  = top_q.ctrl.cpha;
                bus_rdata[CTL_SRC_LSB+1:CTL_SRC_LSB]     = top_q.ctrl.src;
                bus_rdata[CTL_IRQEN_BIT]                 = top_q.ctrl.irq_en;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq = done_flag && top_q.ctrl.irq_en;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (top_q.ctrl == $past(bus_wdata[CTL_IRQEN_BIT:0]))); // R2
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(top_q.ctrl)); // R2
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flag && top_q.ctrl.irq_en)); // R10

endmodule

// File: tb/tws_unit_test.sv
`timescale 1ns/1ps
module tws_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk_pin = 1'b0;
    logic       tmr_match = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo, sclk_out, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tws_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_pin(sclk_pin),
        .tmr_match(tmr_match), .sdi(sdi), .sdo(sdo), .sclk_out(sclk_out), .irq(irq)
    );

    // Behavioural reference model
    int m_sr, m_obit, m_cnt, m_flag, m_cpha, m_src, m_irqen, m_sclk;
    bit hist[$];

    initial begin
        hist = '{1'b0, 1'b0, 1'b0};
    end

    always @(posedge clk) begin
        bit e, r, samp, ovf, wd, ws, wc;
        if (!rst_n) begin
            m_sr = 0; m_obit = 0; m_cnt = 0; m_flag = 0;
            m_cpha = 0; m_src = 0; m_irqen = 0; m_sclk = 0;
            hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            wd = bus_wr && bus_sel == 2'd0;
            ws = bus_wr && bus_sel == 2'd1;
            wc = bus_wr && bus_sel == 2'd2;
            if (m_src == 1) begin
                e = (hist[1] != hist[2]);
                r = hist[1];
            end else begin
                e = (m_src == 2 && tmr_match) || (m_src == 3 && wc && bus_wdata[4]);
                r = (m_sclk == 0);
                if (e) m_sclk = 1 - m_sclk;
            end
            hist.push_front(sclk_pin);
            void'(hist.pop_back());
            samp = r ^ m_cpha[0];
            ovf = e && (m_cnt == 15);
            if (wd) begin
                m_sr = bus_wdata;
                m_obit = bus_wdata[7];
            end else if (e) begin
                if (samp) m_sr = ((m_sr << 1) | sdi) & 8'hFF;
                else m_obit = (m_sr >> 7) & 1;
            end
            if (ws) m_cnt = bus_wdata[3:0];
            else if (e) m_cnt = (m_cnt + 1) % 16;
            m_flag = (ovf || (m_flag != 0 && !(ws && bus_wdata[7]))) ? 1 : 0;
            if (wc) begin
                m_cpha = bus_wdata[0];
                m_src = bus_wdata[2:1];
                m_irqen = bus_wdata[3];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        int exp_rd;
        #1;
        case (bus_sel)
            2'd0: exp_rd = m_sr;
            2'd1: exp_rd = (m_flag << 7) | m_cnt;
            2'd2: exp_rd = (m_irqen << 3) | (m_src << 1) | m_cpha;
            default: exp_rd = 0;
        endcase
        if (bus_sel == 2'd0) chk("R7 model data", bus_rdata, exp_rd);
        else if (bus_sel == 2'd1) chk("R6 model status", bus_rdata, exp_rd);
        else chk("R2 model read", bus_rdata, exp_rd);
        chk("R8 model sdo", sdo, m_obit);
        chk("R4 R5 model sclk_out", sclk_out, m_sclk);
        chk("R10 model irq", irq, (m_flag != 0 && m_irqen != 0) ? 1 : 0);
    end

    task automatic bus_write(input logic [1:0] s, input logic [7:0] v, input bit tmr);
        @(negedge clk);
        bus_sel = s; bus_wr = 1'b1; bus_wdata = v; tmr_match = tmr;
        @(negedge clk);
        bus_wr = 1'b0; tmr_match = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        bus_sel = s;
        #1 v = bus_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Full byte exchange driven by software strobes
    task automatic xfer_sw(input logic [7:0] tx, input logic [7:0] rx, input bit mode);
        logic [7:0] v;
        int k;
        bus_write(2'd2, {4'b0000, 1'b1, 2'd3, mode}, 1'b0);
        bus_write(2'd1, 8'h80, 1'b0);
        bus_write(2'd0, tx, 1'b0);
        chk("R2 sdo after data write", sdo, tx[7]);
        for (int n = 1; n <= 16; n++) begin
            sdi = rx[7 - (n - 1) / 2];
            if (n == 16) begin
                bus_read(2'd1, v);
                chk("R7 flag low before last edge", v[7], 0);
            end
            bus_write(2'd2, {4'b0001, 1'b1, 2'd3, mode}, 1'b0);
            k = mode ? (n - 1) / 2 : n / 2;
            if (k == 8) chk("R8 sdo order mode0", sdo, rx[7]);
            else chk(mode ? "R8 sdo order mode1" : "R8 sdo order mode0", sdo, tx[7 - k]);
        end
        bus_read(2'd0, v);
        chk("R7 received byte", v, rx);
        bus_read(2'd1, v);
        chk("R7 flag set and counter wrapped", v, 8'h80);
        chk("R10 irq with enable", irq, 1);
        bus_read(2'd2, v);
        chk("R4 strobe bit reads 0", v, {4'b0000, 1'b1, 2'd3, mode});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(2'd0, v); chk("R1 data reset", v, 0);
        bus_read(2'd1, v); chk("R1 status reset", v, 0);
        bus_read(2'd2, v); chk("R1 control reset", v, 0);
        chk("R1 sdo reset", sdo, 0);
        chk("R1 sclk_out reset", sclk_out, 0);
        chk("R1 irq reset", irq, 0);

        // R2 register access
        bus_write(2'd2, 8'h0B, 1'b0);
        bus_read(2'd2, v); chk("R2 control readback", v, 8'h0B);
        bus_read(2'd3, v); chk("R2 unused select reads 0", v, 0);
        bus_write(2'd0, 8'h96, 1'b0);
        bus_read(2'd0, v); chk("R2 data readback", v, 8'h96);
        chk("R2 sdo follows bit 7", sdo, 1);

        // R7 R8 exchanges in both modes
        xfer_sw(8'hA5, 8'h3C, 1'b0);
        xfer_sw(8'h5A, 8'hC3, 1'b1);

        // R3 unselected sources ignored (software source active)
        bus_write(2'd1, 8'h84, 1'b0);
        bus_write(2'd2, 8'h06, 1'b0);
        bus_write(2'd0, 8'h11, 1'b0);
        bus_write(2'd3, 8'h00, 1'b1);
        sclk_pin = 1'b1;
        repeat (4) @(negedge clk);
        sclk_pin = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(2'd1, v); chk("R3 counter unchanged by timer and pin", v, 8'h04);
        bus_read(2'd0, v); chk("R3 data unchanged by timer and pin", v, 8'h11);
        chk("R3 sclk_out unchanged", sclk_out, 0);
        bus_write(2'd2, 8'h00, 1'b0);
        bus_write(2'd2, 8'h10, 1'b0);
        bus_read(2'd1, v); chk("R3 strobe ignored with no source", v, 8'h04);

        // R5 timer source
        bus_write(2'd2, 8'h04, 1'b0);
        bus_write(2'd3, 8'h00, 1'b1);
        chk("R5 timer toggles sclk_out", sclk_out, 1);
        bus_read(2'd1, v); chk("R5 R6 timer edge counted", v, 8'h05);

        // R11 wrap vs clearing status write in the same cycle
        bus_write(2'd1, 8'h0F, 1'b0);
        bus_write(2'd1, 8'h85, 1'b1);
        bus_read(2'd1, v); chk("R11 wrap beats clear, preset beats increment", v, 8'h85);
        chk("R10 irq off while enable is 0", irq, 0);
        // R11 data write vs shift in the same cycle
        sdi = 1'b1;
        bus_write(2'd0, 8'h42, 1'b1);
        bus_write(2'd0, 8'h42, 1'b1);
        bus_read(2'd0, v); chk("R11 data write beats shift", v, 8'h42);

        // R9 status writes
        bus_write(2'd1, 8'h07, 1'b0);
        bus_read(2'd1, v); chk("R9 flag kept when bit 7 is 0", v, 8'h87);
        bus_write(2'd1, 8'h83, 1'b0);
        bus_read(2'd1, v); chk("R9 flag cleared, counter preset", v, 8'h03);

        // R12 external pin latency and full byte as slave
        bus_write(2'd2, 8'h02, 1'b0);
        bus_write(2'd1, 8'h80, 1'b0);
        bus_sel = 2'd1;
        @(negedge clk);
        sclk_pin = 1'b1;
        @(posedge clk); #1 chk("R12 no effect at first sample", bus_rdata[3:0], 0);
        @(posedge clk); #1 chk("R12 no effect one clock later", bus_rdata[3:0], 0);
        @(posedge clk); #1 chk("R12 counted two clocks later", bus_rdata[3:0], 1);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            sclk_pin = ~sclk_pin;
            sdi = i[0];
            repeat (4) @(negedge clk);
        end
        bus_read(2'd1, v); chk("R12 R7 slave byte completes", v, 8'h80);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule